// File: doc/BRIEF.md
# Integer ALU with Flag Register and Condition Evaluator

This block is the execute-stage arithmetic unit of a small register-to-register instruction set. It takes a 4-bit function selector and two operands: `opnd_a`, read from the source register, and `opnd_b`, read from the destination register. It returns the result of `B op A` on the same cycle, without a register. Both operands always come from registers. No memory value enters the unit.

A three-bit flag register holds zero, sign and signed-overflow. It is the only state in the block and has three named behaviours:
- **RESET**: while `rst_n` is low, the flags are forced to zero=1, sign=0, overflow=0 on the clock edge.
- **CAPTURE**: when `flag_we` is high and the function selector is valid, the flags computed from the current result are loaded on the rising edge.
- **HOLD**: in every other cycle the flags keep their value.

Flag updates come only from arithmetic/logic instructions. The decoder raises `flag_we` for those instructions and for nothing else.

A combinational condition evaluator reads the stored flags, never the flags of the operation currently on the inputs. It reports whether the 4-bit condition selector `cond_sel` is satisfied. Conditional register moves and conditional branches share this one output.

Top module: `alu_cc_unit`

## Requirements
- R1: Function code 0 gives `result` = (`opnd_b` + `opnd_a`) modulo 2^W.
- R2: Function code 1 gives `result` = (`opnd_b` − `opnd_a`) modulo 2^W, meaning the source is subtracted from the destination.
- R3: Function code 2 gives the bitwise AND of the operands. Function code 3 gives their bitwise XOR.
- R4: Function codes 4 to 15 drive `fn_bad` high and `result` to zero. The flags do not change on that edge, even with `flag_we` high. For codes 0 to 3, `fn_bad` is low.
- R5: On a rising edge with `flag_we` high and a valid code, `zf_q` becomes 1 exactly when the result is zero. `sf_q` becomes the result's most significant bit.
- R6: After a captured add, `of_q` is 1 when both operands share a sign and the result's sign differs from it. After a captured subtract, `of_q` is 1 when the operands' signs differ and the result's sign differs from `opnd_b`'s sign. After AND or XOR, `of_q` is 0.
- R7: A rising edge with `rst_n` low (a synchronous reset) sets `zf_q`=1, `sf_q`=0, `of_q`=0.
- R8: On an edge with `flag_we` low, all three flags keep their value, whatever the operands and function.
- R9: `cond_true` depends only on the stored flags and `cond_sel`. With lt = `sf_q` xor `of_q`, the selector values give:
  - 0: always true
  - 1: lt or `zf_q`
  - 2: lt
  - 3: `zf_q`
  - 4: not `zf_q`
  - 5: not lt
  - 6: not lt and not `zf_q`
- R10: For `cond_sel` 7 to 15, `cond_true` is 0 and `cond_bad` is 1. For 0 to 6, `cond_bad` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fn_code | input | 4 | Operation selector |
| opnd_a | input | W | Source-register operand |
| opnd_b | input | W | Destination-register operand |
| flag_we | input | 1 | Load the flags on this edge |
| cond_sel | input | 4 | Condition to evaluate |
| result | output | W | Combinational result of B op A |
| fn_bad | output | 1 | Selector is not one of the four operations |
| zf_q | output | 1 | Stored zero flag |
| sf_q | output | 1 | Stored sign flag |
| of_q | output | 1 | Stored signed-overflow flag |
| cond_true | output | 1 | Selected condition holds on the stored flags |
| cond_bad | output | 1 | Condition selector is out of range |

## Verification
The hardest cases to reach are the signed-overflow boundaries of subtract. Here the operand order matters, and the flag appears only after a capture edge. To reach them, every pairing of the most-positive, most-negative, zero, one and all-ones values runs through all four operations with the flags captured each time.

A second concern is showing that conditions come from the stored flags and not from the live operation. After each capture, the bench drives different operands with `flag_we` low, then sweeps all sixteen condition selectors.

The result path is checked exhaustively over every operand pair at an 8-bit width.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [3:0] {
        FN_ADD = 4'd0,
        FN_SUB = 4'd1,
        FN_AND = 4'd2,
        FN_XOR = 4'd3
    } alu_fn_e;

    typedef enum logic [3:0] {
        CC_ALWAYS = 4'd0,
        CC_LE     = 4'd1,
        CC_LT     = 4'd2,
        CC_EQ     = 4'd3,
        CC_NE     = 4'd4,
        CC_GE     = 4'd5,
        CC_GT     = 4'd6
    } cond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET_VAL = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_cc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   fn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output cc_flags_t    flags_o,
    output logic         fn_bad_o
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MSB = W - 1;

    logic [W-1:0] sum_w;
    logic [W-1:0] diff_w;
    logic         ovf_w;

    assign sum_w  = b_i + a_i;
    assign diff_w = b_i - a_i;

    always_comb begin
        res_o    = '0;
        ovf_w    = 1'b0;
        fn_bad_o = 1'b0;
        unique case (fn_i)
            FN_ADD: begin
                res_o = sum_w;
                ovf_w = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != b_i[MSB]);
            end
            FN_SUB: begin
                res_o = diff_w;
                ovf_w = (a_i[MSB] != b_i[MSB]) && (diff_w[MSB] != b_i[MSB]);
            end
            FN_AND: res_o = b_i & a_i;
            FN_XOR: res_o = b_i ^ a_i;
            default: fn_bad_o = 1'b1;
        endcase
    end

    always_comb begin
        flags_o.zf = (res_o == '0);
        flags_o.sf = res_o[MSB];
        flags_o.of = ovf_w;
    end

    // R2: a value subtracted from itself is zero with no overflow
    always_comb begin
        if (fn_i == FN_SUB && a_i == b_i)
            assert_sub_self_R2: assert (res_o == '0 && !flags_o.of);
    end

    // R6: logic operations never report overflow
    always_comb begin
        if (fn_i == FN_AND || fn_i == FN_XOR)
            assert_logic_no_of_R6: assert (!flags_o.of);
    end

    // R4: an invalid code yields a zero result
    always_comb begin
        if (fn_bad_o)
            assert_bad_fn_zero_R4: assert (res_o == '0);
    end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we_i,
    input  logic      fn_bad_i,
    input  cc_flags_t nxt_i,
    output cc_flags_t q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        FR_RESET   = 2'd0,
        FR_CAPTURE = 2'd1,
        FR_HOLD    = 2'd2
    } fr_action_e;

    fr_action_e action;

    always_comb begin
        if (!rst_n)                   action = FR_RESET;
        else if (we_i && !fn_bad_i)   action = FR_CAPTURE;
        else                          action = FR_HOLD;
    end

    always_ff @(posedge clk) begin
        unique case (action)
            FR_RESET:   q_o <= CC_RESET_VAL;
            FR_CAPTURE: q_o <= nxt_i;
            default:    q_o <= q_o;
        endcase
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(q_o));

    assert_bad_fn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && fn_bad_i) |=> $stable(q_o));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !fn_bad_i) |=> (q_o == $past(nxt_i)));

    assert_reset_val_R7: assert property (@(posedge clk)
        !rst_n |=> (q_o.zf && !q_o.sf && !q_o.of));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import alu_cc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  cc_flags_t  flags_i,
    output logic       take_o,
    output logic       bad_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic lt_w;

    assign lt_w = flags_i.sf ^ flags_i.of;

    always_comb begin
        bad_o = 1'b0;
        unique case (cond_i)
            CC_ALWAYS: take_o = 1'b1;
            CC_LE:     take_o = lt_w | flags_i.zf;
            CC_LT:     take_o = lt_w;
            CC_EQ:     take_o = flags_i.zf;
            CC_NE:     take_o = !flags_i.zf;
            CC_GE:     take_o = !lt_w;
            CC_GT:     take_o = !lt_w && !flags_i.zf;
            default: begin
                take_o = 1'b0;
                bad_o  = 1'b1;
            end
        endcase
    end

    // R10: an out-of-range selector never reports true
    always_comb begin
        if (bad_o)
            assert_bad_cond_false_R10: assert (!take_o);
    end

    // R9: greater and less-or-equal are complements
    always_comb begin
        if (cond_i == CC_GT)
            assert_gt_vs_le_R9: assert (take_o == !(lt_w | flags_i.zf));
    end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   fn_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_we,
    input  logic [3:0]   cond_sel,
    output logic [W-1:0] result,
    output logic         fn_bad,
    output logic         zf_q,
    output logic         sf_q,
    output logic         of_q,
    output logic         cond_true,
    output logic         cond_bad
);
    timeunit 1ns;
    timeprecision 100ps;

    cc_flags_t nxt_flags;
    cc_flags_t cur_flags;

    alu_core #(.W(W)) u_core (
        .fn_i     (fn_code),
        .a_i      (opnd_a),
        .b_i      (opnd_b),
        .res_o    (result),
        .flags_o  (nxt_flags),
        .fn_bad_o (fn_bad)
    );

    cc_flag_reg u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (flag_we),
        .fn_bad_i (fn_bad),
        .nxt_i    (nxt_flags),
        .q_o      (cur_flags)
    );

    cond_eval u_cond (
        .cond_i  (cond_sel),
        .flags_i (cur_flags),
        .take_o  (cond_true),
        .bad_o   (cond_bad)
    );

    assign zf_q = cur_flags.zf;
    assign sf_q = cur_flags.sf;
    assign of_q = cur_flags.of;

    // R9: condition output ignores the live operation while flags hold
    assert_cond_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && $stable(cond_sel)) |=> $stable(cond_true));
endmodule

// File: tb/test_alu_cc_unit.sv
module test_alu_cc_unit;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   fn_code = 4'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         flag_we = 1'b0;
    logic [3:0]   cond_sel = 4'd0;
    logic [W-1:0] result;
    logic         fn_bad, zf_q, sf_q, of_q, cond_true, cond_bad;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    alu_cc_unit #(.W(W)) i_alu_cc_unit (
        .clk(clk), .rst_n(rst_n), .fn_code(fn_code), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .flag_we(flag_we), .cond_sel(cond_sel),
        .result(result), .fn_bad(fn_bad), .zf_q(zf_q), .sf_q(sf_q),
        .of_q(of_q), .cond_true(cond_true), .cond_bad(cond_bad)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int fn, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] r, output logic z, output logic s,
                         output logic o);
        int sa, sb, sr;
        sa = (a >= 128) ? int'(a) - 256 : int'(a);
        sb = (b >= 128) ? int'(b) - 256 : int'(b);
        o = 1'b0;
        case (fn)
            0: begin r = W'((int'(b) + int'(a)) % 256); sr = sb + sa; o = (sr > 127 || sr < -128); end
            1: begin r = W'((int'(b) - int'(a) + 256) % 256); sr = sb - sa; o = (sr > 127 || sr < -128); end
            2: r = b & a;
            default: r = b ^ a;
        endcase
        z = (r == 0);
        s = (r >= 128);
    endtask

    function automatic logic cond_ref(input int c, input logic z, input logic s, input logic o);
        logic lt;
        lt = s ^ o;
        case (c)
            0: return 1'b1;
            1: return lt | z;
            2: return lt;
            3: return z;
            4: return !z;
            5: return !lt;
            6: return !lt && !z;
            default: return 1'b0;
        endcase
    endfunction

    // capture one operation, check flags, then sweep conditions with other inputs live
    task automatic cap_and_sweep(input int fn, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic z, s, o;
        fn_code = 4'(fn); opnd_a = a; opnd_b = b; flag_we = 1'b1;
        @(posedge clk); @(negedge clk);
        model(fn, a, b, r, z, s, o);
        chk(zf_q == z, "R5 zf", 64'(zf_q), 64'(z));
        chk(sf_q == s, "R5 sf", 64'(sf_q), 64'(s));
        chk(of_q == o, "R6 of", 64'(of_q), 64'(o));
        flag_we = 1'b0;
        opnd_a = ~a; opnd_b = a ^ 8'h5a;
        for (int c = 0; c < 16; c++) begin
            cond_sel = 4'(c);
            #0.1;
            chk(cond_true == cond_ref(c, z, s, o), (c > 6) ? "R10 cond_true" : "R9 cond_true",
                64'(cond_true), 64'(cond_ref(c, z, s, o)));
            chk(cond_bad == (c > 6), "R10 cond_bad", 64'(cond_bad), 64'(c > 6));
        end
    endtask

    initial begin
        #950000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corner [5];
        logic [W-1:0] r;
        logic z, s, o;
        corner = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff};

        repeat (3) @(negedge clk);
        // R7 reset state
        chk(zf_q == 1'b1 && sf_q == 1'b0 && of_q == 1'b0, "R7 reset flags",
            {61'd0, zf_q, sf_q, of_q}, 64'h4);
        cond_sel = 4'd3; #0.1;
        chk(cond_true == 1'b1, "R9 eq after reset", 64'(cond_true), 64'd1);
        cond_sel = 4'd4; #0.1;
        chk(cond_true == 1'b0, "R9 ne after reset", 64'(cond_true), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 exhaustive result sweep with flag_we low
        for (int fn = 0; fn < 4; fn++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    fn_code = 4'(fn); opnd_a = W'(a); opnd_b = W'(b);
                    #1;
                    model(fn, W'(a), W'(b), r, z, s, o);
                    chk(result == r, (fn == 0) ? "R1 add" : (fn == 1) ? "R2 sub" : "R3 logic",
                        64'(result), 64'(r));
                    chk(fn_bad == 1'b0, "R4 valid code", 64'(fn_bad), 64'd0);
                end
            end
        end
        @(negedge clk);
        // R8 flags untouched by the whole sweep
        chk(zf_q == 1'b1 && sf_q == 1'b0 && of_q == 1'b0, "R8 hold through sweep",
            {61'd0, zf_q, sf_q, of_q}, 64'h4);

        // R5 R6 R9 R10 corner pairs
        for (int fn = 0; fn < 4; fn++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    cap_and_sweep(fn, corner[i], corner[j]);

        // R5 R6 strided sweep
        for (int fn = 0; fn < 4; fn++)
            for (int a = 0; a < 256; a += 9)
                for (int b = 3; b < 256; b += 11)
                    cap_and_sweep(fn, W'(a), W'(b));

        // R8 hold: load sf=1 of=1 zf=0, then present a zero result with we low
        @(negedge clk);
        cap_and_sweep(0, 8'h01, 8'h7f);
        fn_code = 4'd1; opnd_a = 8'h33; opnd_b = 8'h33; flag_we = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(zf_q == 1'b0 && sf_q == 1'b1 && of_q == 1'b1, "R8 hold with we low",
            {61'd0, zf_q, sf_q, of_q}, 64'h3);

        // R4 invalid codes with we high
        for (int fn = 4; fn < 16; fn++) begin
            fn_code = 4'(fn); opnd_a = 8'h00; opnd_b = 8'h00; flag_we = 1'b1;
            #1;
            chk(fn_bad == 1'b1, "R4 fn_bad", 64'(fn_bad), 64'd1);
            chk(result == '0, "R4 result zero", 64'(result), 64'd0);
            @(posedge clk); @(negedge clk);
            chk(zf_q == 1'b0 && sf_q == 1'b1 && of_q == 1'b1, "R4 flags unchanged",
                {61'd0, zf_q, sf_q, of_q}, 64'h3);
        end
        flag_we = 1'b0;

        // R7 reset in mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(zf_q == 1'b1 && sf_q == 1'b0 && of_q == 1'b0, "R7 reset mid-run",
            {61'd0, zf_q, sf_q, of_q}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule